// File: doc/BRIEF.md
# Virtual Address Hole Checker

This block screens virtual addresses against an implemented address space that is narrower than the full virtual width. With the default sizes, the virtual width is 64 bits and 44 bits are implemented. An address is legal only when its bits from the top down to bit 43 all carry the same value. Every other address lies in the unimplemented gap, called the hole. Each fetch strobe and each data-access strobe is checked. When the address falls in the hole, the block produces a one-cycle trap request for the matching exception. A data access is not treated as being in the hole while the 32-bit address-masking mode is on. Whenever a request is raised, the low implemented bits of the offending address are latched for the fault-address register.

The block also tracks whether the saved next-PC points into the hole. The pipeline reports each trap entry together with the next-PC value saved at that moment. This covers a delay slot whose branch or call target is out of range, and the last instruction just below the hole. If the saved next-PC lies in the hole, a flag is set. A later DONE/RETRY that finds the flag set arms a deferred fault, and the next fetch then traps whatever its address is. If software writes the next-PC before returning, the flag is dropped and no deferred fault occurs.

Top module: `va_hole_checker`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `iae_req`, `dae_req`, `npc_oor` and `fault_addr` are all zero.
- R2: A cycle with `fetch_vld` high and a `fetch_va` whose bits 63..43 are not all equal produces `iae_req` high in the following cycle. A `fetch_va` with bits 63..43 all zeros or all ones produces no request.
- R3: A cycle with `data_vld` high, `addr_mask` low and a `data_va` in the hole (bits 63..43 not all equal) produces `dae_req` high in the following cycle. An in-range `data_va` produces no request.
- R4: While `addr_mask` is high, no data address produces `dae_req`, because only its low 32 bits are considered.
- R5: Trap requests are one cycle long and are qualified by their strobes. Without `fetch_vld` or `data_vld`, no request follows, whatever address is on the bus.
- R6: When a request is raised, `fault_addr` takes bits 43..0 of the offending address in the same cycle as the request. It holds that value until the next request. If fetch and data both trap in one cycle, the fetch address is latched.
- R7: A cycle with `trap_vld` high sets `npc_oor` in the following cycle exactly when `trap_npc` lies in the hole. This covers an out-of-range branch target and the address just past the last instruction below the hole (0x0000_0800_0000_0000). A trap entry whose `trap_npc` is in range clears the flag.
- R8: `npc_wr` without `trap_vld` clears `npc_oor`, and a later `ret_vld` then raises no deferred fault.
- R9: `ret_vld` while `npc_oor` is set clears the flag and arms a deferred fault. The next `fetch_vld` then produces `iae_req`, even for an in-range address, with `fault_addr` set to that fetch address. The fault fires once.
- R10: When `trap_vld` and `npc_wr` arrive in the same cycle, the trap's recording wins. `ret_vld` together with `npc_wr` arms nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_vld | input | 1 | Instruction fetch strobe |
| fetch_va | input | 64 | Instruction fetch virtual address |
| data_vld | input | 1 | Data access strobe |
| data_va | input | 64 | Data access virtual address |
| addr_mask | input | 1 | 32-bit address masking mode |
| trap_vld | input | 1 | Trap entry, next-PC saved |
| trap_npc | input | 64 | Next-PC value saved at trap entry |
| npc_wr | input | 1 | Software write of the saved next-PC |
| ret_vld | input | 1 | DONE/RETRY executed |
| iae_req | output | 1 | Instruction access exception request pulse |
| dae_req | output | 1 | Data access exception request pulse |
| fault_addr | output | 44 | Truncated fault address |
| npc_oor | output | 1 | Saved next-PC lies in the hole |

## Verification
The deferred fault is the hard case to reach. It needs a trap entry with an out-of-range next-PC, then a return, and then a fetch whose own address is legal. Only a request on that fetch shows that the fault was armed. The stimulus runs this sequence several ways: with a rewrite of the next-PC in between, with the trap and the write in one cycle, and with the return and the write in one cycle. A follow-up fetch then checks that the fault fires only once. The range compare is swept with single-bit and inverted single-bit patterns across all 64 positions, for fetch and for data with masking on and off. The expected hole decision comes from a signed-range test in the bench.

// File: rtl/va_hole_pkg.sv
package va_hole_pkg;
   typedef enum logic [1:0] {
      SRC_NONE  = 2'd0,
      SRC_FETCH = 2'd1,
      SRC_DATA  = 2'd2
   } fault_src_e;
endpackage

// File: rtl/va_range_cmp.sv
module va_range_cmp #(
   parameter int VA_W     = 64,
   parameter int IMPL_W   = 44,
   parameter int AM_W     = 32,
   parameter bit HAS_MASK = 1'b0
) (
   input  logic [VA_W-1:0] va,
   input  logic            mask_en,
   output logic            in_hole
);
   localparam int TOP_W = VA_W - IMPL_W + 1;

   logic [VA_W-1:0]  eff_va;
   logic [TOP_W-1:0] upper;

   generate
      if (HAS_MASK) begin : g_masked
         always_comb begin
            if (mask_en) eff_va = {{(VA_W-AM_W){1'b0}}, va[AM_W-1:0]};
            else         eff_va = va;
         end
      end else begin : g_plain
         logic unused_mask;
         assign unused_mask = mask_en;
         assign eff_va      = va;
      end
   endgenerate

   assign upper   = eff_va[VA_W-1:IMPL_W-1];
   assign in_hole = (|upper) && !(&upper);

   logic unused_low;
   assign unused_low = ^eff_va[IMPL_W-2:0];
endmodule

// File: rtl/va_npc_tracker.sv
module va_npc_tracker (
   input  logic clk,
   input  logic rst_n,
   input  logic trap_vld,
   input  logic npc_hole,
   input  logic npc_wr,
   input  logic ret_vld,
   input  logic fetch_vld,
   output logic npc_oor,
   output logic armed
);
   logic flag_q, armed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         if (trap_vld)               flag_q <= npc_hole;
         else if (npc_wr || ret_vld) flag_q <= 1'b0;

         if (ret_vld && flag_q && !npc_wr) armed_q <= 1'b1;
         else if (fetch_vld)               armed_q <= 1'b0;
      end
   end

   assign npc_oor = flag_q;
   assign armed   = armed_q;
endmodule

// File: rtl/va_fault_capture.sv
module va_fault_capture #(
   parameter int VA_W   = 64,
   parameter int IMPL_W = 44
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_hit,
   input  logic [VA_W-1:0]   fetch_va,
   input  logic              data_hit,
   input  logic [VA_W-1:0]   data_va,
   output logic [IMPL_W-1:0] fault_addr
);
   import va_hole_pkg::*;

   fault_src_e        src;
   logic [IMPL_W-1:0] addr_q;

   always_comb begin
      if (fetch_hit)     src = SRC_FETCH;
      else if (data_hit) src = SRC_DATA;
      else               src = SRC_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) addr_q <= '0;
      else begin
         case (src)
            SRC_FETCH: addr_q <= fetch_va[IMPL_W-1:0];
            SRC_DATA:  addr_q <= data_va[IMPL_W-1:0];
            default:   addr_q <= addr_q;
         endcase
      end
   end

   assign fault_addr = addr_q;

   logic unused_hi;
   assign unused_hi = ^{fetch_va[VA_W-1:IMPL_W], data_va[VA_W-1:IMPL_W]};
endmodule

// File: rtl/va_hole_checker.sv
module va_hole_checker #(
   parameter int VA_W   = 64,
   parameter int IMPL_W = 44,
   parameter int AM_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_vld,
   input  logic [VA_W-1:0]   fetch_va,
   input  logic              data_vld,
   input  logic [VA_W-1:0]   data_va,
   input  logic              addr_mask,
   input  logic              trap_vld,
   input  logic [VA_W-1:0]   trap_npc,
   input  logic              npc_wr,
   input  logic              ret_vld,
   output logic              iae_req,
   output logic              dae_req,
   output logic [IMPL_W-1:0] fault_addr,
   output logic              npc_oor
);
   generate
      if (IMPL_W < 2 || IMPL_W >= VA_W) begin : g_bad_impl
         $error("IMPL_W must lie between 2 and VA_W-1");
      end
      if (AM_W < 1 || AM_W >= IMPL_W) begin : g_bad_am
         $error("AM_W must be below IMPL_W");
      end
   endgenerate

   logic fetch_hole, data_hole, npc_hole, armed;
   logic iae_hit, dae_hit;
   logic iae_q, dae_q;

   va_range_cmp #(.VA_W(VA_W), .IMPL_W(IMPL_W), .AM_W(AM_W), .HAS_MASK(1'b0)) u_fetch_cmp (
      .va(fetch_va), .mask_en(1'b0), .in_hole(fetch_hole));

   va_range_cmp #(.VA_W(VA_W), .IMPL_W(IMPL_W), .AM_W(AM_W), .HAS_MASK(1'b1)) u_data_cmp (
      .va(data_va), .mask_en(addr_mask), .in_hole(data_hole));

   va_range_cmp #(.VA_W(VA_W), .IMPL_W(IMPL_W), .AM_W(AM_W), .HAS_MASK(1'b0)) u_npc_cmp (
      .va(trap_npc), .mask_en(1'b0), .in_hole(npc_hole));

   va_npc_tracker u_tracker (
      .clk(clk), .rst_n(rst_n), .trap_vld(trap_vld), .npc_hole(npc_hole),
      .npc_wr(npc_wr), .ret_vld(ret_vld), .fetch_vld(fetch_vld),
      .npc_oor(npc_oor), .armed(armed));

   assign iae_hit = fetch_vld && (fetch_hole || armed);
   assign dae_hit = data_vld && data_hole;

   va_fault_capture #(.VA_W(VA_W), .IMPL_W(IMPL_W)) u_capture (
      .clk(clk), .rst_n(rst_n), .fetch_hit(iae_hit), .fetch_va(fetch_va),
      .data_hit(dae_hit), .data_va(data_va), .fault_addr(fault_addr));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         iae_q <= 1'b0;
         dae_q <= 1'b0;
      end else begin
         iae_q <= iae_hit;
         dae_q <= dae_hit;
      end
   end

   assign iae_req = iae_q;
   assign dae_req = dae_q;
endmodule

// File: rtl/va_hole_checker_sva.sv
module va_hole_checker_sva #(
   parameter int IMPL_W = 44
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fetch_vld,
   input logic              data_vld,
   input logic              addr_mask,
   input logic              trap_vld,
   input logic              npc_wr,
   input logic              ret_vld,
   input logic              iae_req,
   input logic              dae_req,
   input logic [IMPL_W-1:0] fault_addr,
   input logic              npc_oor
);
   p_iae_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      iae_req |-> $past(fetch_vld));

   p_dae_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dae_req |-> $past(data_vld));

   p_mask_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (data_vld && addr_mask) |=> !dae_req);

   p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_vld && !data_vld) |=> (!iae_req && !dae_req));

   p_fault_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!iae_req && !dae_req) |-> $stable(fault_addr));

   p_flag_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(npc_oor) |-> $past(trap_vld));

   p_wr_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (npc_wr && !trap_vld) |=> !npc_oor);

   p_ret_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_vld && !trap_vld) |=> !npc_oor);
endmodule

bind va_hole_checker va_hole_checker_sva #(.IMPL_W(IMPL_W)) u_sva (
   .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .data_vld(data_vld),
   .addr_mask(addr_mask), .trap_vld(trap_vld), .npc_wr(npc_wr), .ret_vld(ret_vld),
   .iae_req(iae_req), .dae_req(dae_req), .fault_addr(fault_addr), .npc_oor(npc_oor));

// File: tb/va_hole_checker_test.sv
module va_hole_checker_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_vld = 1'b0, data_vld = 1'b0, addr_mask = 1'b0;
   logic [63:0] fetch_va = '0, data_va = '0, trap_npc = '0;
   logic        trap_vld = 1'b0, npc_wr = 1'b0, ret_vld = 1'b0;
   logic        iae_req, dae_req, npc_oor;
   logic [43:0] fault_addr;

   int checks = 0;
   int errors = 0;
   logic [43:0] exp_fault = '0;

   always #4 clk = ~clk;

   va_hole_checker uut (
      .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .fetch_va(fetch_va),
      .data_vld(data_vld), .data_va(data_va), .addr_mask(addr_mask),
      .trap_vld(trap_vld), .trap_npc(trap_npc), .npc_wr(npc_wr), .ret_vld(ret_vld),
      .iae_req(iae_req), .dae_req(dae_req), .fault_addr(fault_addr), .npc_oor(npc_oor));

   function automatic logic ref_hole(input logic [63:0] va);
      logic signed [63:0] s;
      s = $signed(va);
      return !((s >= -(64'sd1 <<< 43)) && (s < (64'sd1 <<< 43)));
   endfunction

   task automatic chk(input logic ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic access(input logic fv, input logic [63:0] fa, input logic dv,
                         input logic [63:0] da, input logic am,
                         input logic exp_i, input logic exp_d, input string req);
      @(negedge clk);
      fetch_vld = fv; fetch_va = fa; data_vld = dv; data_va = da; addr_mask = am;
      @(negedge clk);
      fetch_vld = 1'b0; data_vld = 1'b0;
      if (exp_i)      exp_fault = fa[43:0];
      else if (exp_d) exp_fault = da[43:0];
      chk(iae_req == exp_i, {req, " iae"}, 64'(iae_req), 64'(exp_i));
      chk(dae_req == exp_d, {req, " dae"}, 64'(dae_req), 64'(exp_d));
      chk(fault_addr == exp_fault, {"R6 ", req, " fault_addr"}, 64'(fault_addr), 64'(exp_fault));
      @(negedge clk);
      chk(!iae_req && !dae_req, "R5 pulse length", {62'd0, iae_req, dae_req}, 64'd0);
   endtask

   task automatic ctl(input logic tv, input logic [63:0] npc, input logic wr,
                      input logic rt, input logic exp_flag, input string req);
      @(negedge clk);
      trap_vld = tv; trap_npc = npc; npc_wr = wr; ret_vld = rt;
      @(negedge clk);
      trap_vld = 1'b0; npc_wr = 1'b0; ret_vld = 1'b0;
      chk(npc_oor == exp_flag, {req, " npc_oor"}, 64'(npc_oor), 64'(exp_flag));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!iae_req && !dae_req && !npc_oor && fault_addr == 0, "R1 in reset",
          {fault_addr, 17'd0, iae_req, dae_req, npc_oor}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!iae_req && !dae_req && !npc_oor && fault_addr == 0, "R1 after reset",
          {fault_addr, 17'd0, iae_req, dae_req, npc_oor}, 64'd0);

      // R2 fetch sweep, R3/R4 data sweep
      for (int b = 0; b < 64; b++) begin
         logic [63:0] p, n;
         p = 64'd1 << b;
         n = ~p;
         access(1'b1, p, 1'b0, '0, 1'b0, ref_hole(p), 1'b0, "R2 single bit");
         access(1'b1, n, 1'b0, '0, 1'b0, ref_hole(n), 1'b0, "R2 inverted bit");
         access(1'b0, '0, 1'b1, p, 1'b0, 1'b0, ref_hole(p), "R3 single bit");
         access(1'b0, '0, 1'b1, n, 1'b0, 1'b0, ref_hole(n), "R3 inverted bit");
         access(1'b0, '0, 1'b1, p, 1'b1, 1'b0, 1'b0, "R4 masked bit");
         access(1'b0, '0, 1'b1, n, 1'b1, 1'b0, 1'b0, "R4 masked inverted");
      end

      // R5: hole addresses on the bus without strobes
      access(1'b0, 64'h8000_0000_0000_0000, 1'b0, 64'h0000_1000_0000_0000, 1'b0,
             1'b0, 1'b0, "R5 no strobe");
      // R6: both trap at once, fetch address latched
      access(1'b1, 64'h1234_5678_9ABC_DEF0, 1'b1, 64'h0F00_0000_0000_0ABC, 1'b0,
             1'b1, 1'b1, "R6 priority");
      access(1'b1, 64'hFFFF_F800_0000_0010, 1'b1, 64'h0000_07FF_FFFF_FFFC, 1'b0,
             1'b0, 1'b0, "R6 edges in range");

      // R7 and R9: last instruction below the hole, then DONE/RETRY
      ctl(1'b1, 64'h0000_0800_0000_0000, 1'b0, 1'b0, 1'b1, "R7 below hole");
      ctl(1'b0, '0, 1'b0, 1'b1, 1'b0, "R9 ret clears");
      access(1'b1, 64'h0000_0000_0000_1000, 1'b0, '0, 1'b0, 1'b1, 1'b0, "R9 deferred");
      access(1'b1, 64'h0000_0000_0000_1004, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R9 fires once");

      // R7 out-of-range branch target, then in-range trap clears
      ctl(1'b1, 64'h4000_0000_0000_0000, 1'b0, 1'b0, 1'b1, "R7 branch target");
      ctl(1'b1, 64'hFFFF_FFFF_FFFF_0000, 1'b0, 1'b0, 1'b0, "R7 in-range trap");
      ctl(1'b0, '0, 1'b0, 1'b1, 1'b0, "R7 ret after clear");
      access(1'b1, 64'h2000, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R7 no deferred");

      // R8: rewrite of next-PC drops the flag
      ctl(1'b1, 64'h0001_0000_0000_0000, 1'b0, 1'b0, 1'b1, "R8 set");
      ctl(1'b0, '0, 1'b1, 1'b0, 1'b0, "R8 write clears");
      ctl(1'b0, '0, 1'b0, 1'b1, 1'b0, "R8 ret");
      access(1'b1, 64'h3000, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R8 no deferred");

      // R10: simultaneous events
      ctl(1'b1, 64'h0002_0000_0000_0000, 1'b1, 1'b0, 1'b1, "R10 trap beats write");
      ctl(1'b0, '0, 1'b1, 1'b1, 1'b0, "R10 ret with write");
      access(1'b1, 64'h4000, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R10 no arm");

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule